// File: doc/BRIEF.md
# Page Write Buffer with Protected Upper Quarter

This block sits behind a serial memory slave's protocol engine and handles the write side of a byte-wide nonvolatile store. After a write transaction opens and the two-byte address has been taken, each received data byte goes into a 32-entry row buffer. The slot is picked by a 5-bit column counter. The counter steps after every byte and wraps inside the row, so the row bits never change during a transaction. A per-slot flag records which slots were filled.

A stop strobe that arrives in the slot directly after an acknowledge starts a commit. The block then raises `busy` for a fixed number of clock cycles and writes only the filled slots into the internal storage array. Any other stop drops the buffered bytes. A write-control level is sampled on every cycle from the start of the transaction through the cycle that loads the address. If it is seen high at any of those samples, the upper quarter of the address space is locked for that transaction. Bytes aimed at the locked quarter are not acknowledged and are not stored.

A combinational read port onto the array serves the read path. `next_addr` gives the address the next current-address read would use.

Top module: `page_write_buffer`

## Requirements
- R1: After reset every array byte reads FFh, `busy` is low, `data_ack` is low and `next_addr` is zero.
- R2: A data byte is placed at column `{next_addr[4:0]}`. The column then steps by one and wraps from 31 to 0 without touching the row bits. A later byte sent to a column already filled in the same transaction replaces the earlier one.
- R3: The stored bytes reach the array only after `stop_commit`. A `stop_abort` pulse leaves the array unchanged, and so does a new transaction that opens without a commit.
- R4: A commit writes only the slots filled in the current transaction. Every other byte of the row keeps its old value.
- R5: If `wc_pin` is high on any cycle from the accepted `txn_start` through the `addr_load` cycle, then bytes whose address has bits [ADDR_W-1:ADDR_W-2] equal to 2'b11 are not acknowledged (`data_ack` low) and those locations are not modified.
- R6: With `wc_pin` low through that window, bytes in every quarter are acknowledged and written. A locked transaction still writes and acknowledges addresses outside the upper quarter.
- R7: `busy` rises on the cycle after an accepted `stop_commit` and stays high for exactly WRITE_CYCLES cycles. While it is high, `txn_start`, `addr_load`, `byte_valid` and both stop strobes have no effect, and `data_ack` stays low.
- R8: `next_addr` equals `{row, column}`. After a transaction it points one past the last byte received, wrapped inside the row.
- R9: `wc_pin` changes after the `addr_load` cycle do not change the lock decision of the running transaction.
- R10: A `stop_commit` when no slot was filled returns the block to idle without raising `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Pulse: a write transaction opens (start plus write select) |
| addr_load | input | 1 | Pulse: both address bytes are received and `addr_in` is valid |
| addr_in | input | ADDR_W | Full byte address for the transaction |
| byte_valid | input | 1 | Pulse: a data byte has been received |
| byte_data | input | 8 | Received data byte |
| stop_commit | input | 1 | Stop seen in the slot right after an acknowledge |
| stop_abort | input | 1 | Stop seen anywhere else |
| wc_pin | input | 1 | Write control level; high locks the upper quarter |
| data_ack | output | 1 | The current data byte is acknowledged |
| busy | output | 1 | Timed commit cycle in progress |
| next_addr | output | ADDR_W | Row and column pointer for the next access |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
Embedded properties check the following on every cycle: the column steps on each accepted byte, the filled-slot mask is empty after a transaction opens, a high write-control level inside the window sets the lock, the array is never written in the locked quarter, and `busy` starts only after a commit strobe, holds until its count ends and stays low after an empty commit. Other behaviour can be shown only by scenarios that read the array back through the read port and compare it to a model kept by the bench. These are wrap and overwrite inside a row, discard on an abort, untouched neighbour bytes, the exact length of the busy period, and strobes ignored while busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int SLOT_W = 5;
    localparam int SLOTS  = 1 << SLOT_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_BUSY = 2'd3
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
    } commit_t;

    // Upper quarter of the address space: both top row bits set.
    function automatic logic in_locked_quarter(input logic [1:0] top_bits);
        return top_bits == 2'b11;
    endfunction

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int WRITE_CYCLES = 40
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    txn_start_i,
    input  logic    addr_load_i,
    input  logic    stop_commit_i,
    input  logic    stop_abort_i,
    input  logic    any_valid_i,
    output phase_e  phase_o,
    output logic    busy_o,
    output commit_t commit_o
);

    localparam int CYC_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CYC_W-1:0] LAST_CNT  = CYC_W'(WRITE_CYCLES - 1);
    localparam logic [CYC_W-1:0] SLOT_LIM  = CYC_W'(SLOTS);

    phase_e           phase_q;
    logic [CYC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (txn_start_i) phase_q <= PH_ADDR;
                end
                PH_ADDR: begin
                    if (txn_start_i)                       phase_q <= PH_ADDR;
                    else if (addr_load_i)                  phase_q <= PH_DATA;
                    else if (stop_commit_i || stop_abort_i) phase_q <= PH_IDLE;
                end
                PH_DATA: begin
                    if (txn_start_i) begin
                        phase_q <= PH_ADDR;
                    end else if (stop_commit_i) begin
                        phase_q <= any_valid_i ? PH_BUSY : PH_IDLE;
                        cnt_q   <= '0;
                    end else if (stop_abort_i) begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_BUSY: begin
                    if (cnt_q == LAST_CNT) phase_q <= PH_IDLE;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o       = phase_q;
    assign busy_o        = (phase_q == PH_BUSY);
    assign commit_o.en   = (phase_q == PH_BUSY) && (cnt_q < SLOT_LIM);
    assign commit_o.slot = cnt_q[SLOT_W-1:0];

    // R7: busy only ever begins after a commit strobe
    a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_commit_i));

    // R7: busy is held until the count reaches its end
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q != LAST_CNT) |=> busy_o);

    // R10: an empty commit never starts the busy period
    a_r10_empty_commit: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && !txn_start_i && stop_commit_i && !any_valid_i) |=> !busy_o);

endmodule

// File: rtl/pwb_wc_guard.sv
module pwb_wc_guard (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic close_i,
    input  logic wc_i,
    output logic lock_o
);

    logic win_q;
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= 1'b0;
            lock_q <= 1'b0;
        end else if (start_i) begin
            win_q  <= 1'b1;
            lock_q <= wc_i;
        end else if (win_q) begin
            lock_q <= lock_q | wc_i;
            if (close_i) win_q <= 1'b0;
        end
    end

    assign lock_o = lock_q;

    // R5: a high level seen inside the window locks the quarter
    a_r5_wc_sticky: assert property (@(posedge clk) disable iff (rst)
        ((win_q || start_i) && wc_i) |=> lock_o);

    // R9: outside the window the lock decision is frozen
    a_r9_lock_frozen: assert property (@(posedge clk) disable iff (rst)
        (!win_q && !start_i) |=> $stable(lock_o));

endmodule

// File: rtl/pwb_row_buffer.sv
module pwb_row_buffer
    import pwb_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear_i,
    input  logic                    set_i,
    input  logic [ROW_W+SLOT_W-1:0] addr_i,
    input  logic                    adv_i,
    input  logic                    store_i,
    input  logic [7:0]              data_i,
    input  logic [SLOT_W-1:0]       rd_slot_i,
    output logic [ROW_W-1:0]        row_o,
    output logic [SLOT_W-1:0]       col_o,
    output logic                    any_valid_o,
    output logic                    rd_valid_o,
    output logic [7:0]              rd_data_o
);

    logic [ROW_W-1:0]  row_q;
    logic [SLOT_W-1:0] col_q;
    logic [SLOTS-1:0]  valid_vec;
    logic [7:0]        slot_d [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (set_i) begin
            row_q <= addr_i[ROW_W+SLOT_W-1:SLOT_W];
            col_q <= addr_i[SLOT_W-1:0];
        end else if (adv_i) begin
            col_q <= col_q + 1'b1;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic       v_q;
        logic [7:0] d_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (clear_i) begin
                v_q <= 1'b0;
            end else if (adv_i && store_i && col_q == SLOT_W'(g)) begin
                v_q <= 1'b1;
                d_q <= data_i;
            end
        end
        assign valid_vec[g] = v_q;
        assign slot_d[g]    = d_q;
    end

    assign row_o       = row_q;
    assign col_o       = col_q;
    assign any_valid_o = |valid_vec;
    assign rd_valid_o  = valid_vec[rd_slot_i];
    assign rd_data_o   = slot_d[rd_slot_i];

    // R2: each accepted byte steps the column by one, wrapping in the row
    a_r2_col_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !set_i) |=> col_o == $past(col_o) + 1'b1);

    // R4: a new transaction starts with no filled slot
    a_r4_mask_cleared: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !any_valid_o);

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              stop_commit,
    input  logic              stop_abort,
    input  logic              wc_pin,
    output logic              data_ack,
    output logic              busy,
    output logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int ROW_W = ADDR_W - SLOT_W;

    phase_e            phase;
    commit_t           commit;
    logic              lock;
    logic              any_valid;
    logic              slot_valid;
    logic [7:0]        slot_data;
    logic [ROW_W-1:0]  row;
    logic [SLOT_W-1:0] col;
    logic              in_data;
    logic              row_locked;
    logic              open_txn;
    logic              take_addr;
    logic              adv_byte;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;

    assign in_data    = (phase == PH_DATA);
    assign row_locked = lock && in_locked_quarter(row[ROW_W-1 -: 2]);
    assign open_txn   = txn_start && (phase != PH_BUSY);
    assign take_addr  = (phase == PH_ADDR) && addr_load && !txn_start;
    assign adv_byte   = in_data && byte_valid && !txn_start;
    assign data_ack   = in_data && !row_locked;

    pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .txn_start_i   (txn_start),
        .addr_load_i   (addr_load),
        .stop_commit_i (stop_commit),
        .stop_abort_i  (stop_abort),
        .any_valid_i   (any_valid),
        .phase_o       (phase),
        .busy_o        (busy),
        .commit_o      (commit)
    );

    pwb_wc_guard guard_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (open_txn),
        .close_i (take_addr),
        .wc_i    (wc_pin),
        .lock_o  (lock)
    );

    pwb_row_buffer #(.ROW_W(ROW_W)) rowbuf_i (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (open_txn),
        .set_i       (take_addr),
        .addr_i      (addr_in),
        .adv_i       (adv_byte),
        .store_i     (data_ack),
        .data_i      (byte_data),
        .rd_slot_i   (commit.slot),
        .row_o       (row),
        .col_o       (col),
        .any_valid_o (any_valid),
        .rd_valid_o  (slot_valid),
        .rd_data_o   (slot_data)
    );

    assign mem_we   = commit.en && slot_valid;
    assign mem_addr = {row, commit.slot};

    pwb_array #(.ADDR_W(ADDR_W)) array_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mem_we),
        .waddr_i (mem_addr),
        .wdata_i (slot_data),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    assign next_addr = {row, col};

    // R5: the locked quarter is never written while the lock is held
    a_r5_no_locked_write: assert property (@(posedge clk) disable iff (rst)
        (mem_we && lock) |-> !in_locked_quarter(mem_addr[ADDR_W-1 -: 2]));

    // R7: nothing is acknowledged during the busy period
    a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !data_ack);

    // R7: the row pointer does not move while busy
    a_r7_row_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(next_addr));

endmodule

// File: tb/page_write_buffer_tb_top.sv
`timescale 1ns/1ps
module page_write_buffer_tb_top;

    localparam int AW   = 10;
    localparam int WCYC = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic          txn_start, addr_load, byte_valid, stop_commit, stop_abort, wc_pin;
    logic [AW-1:0] addr_in, rd_addr;
    logic [7:0]    byte_data;
    logic          data_ack, busy;
    logic [AW-1:0] next_addr;
    logic [7:0]    rd_data;

    always #2.5 clk = ~clk;

    page_write_buffer #(.ADDR_W(AW), .WRITE_CYCLES(WCYC)) dut_i (
        .clk(clk), .rst(rst), .txn_start(txn_start), .addr_load(addr_load),
        .addr_in(addr_in), .byte_valid(byte_valid), .byte_data(byte_data),
        .stop_commit(stop_commit), .stop_abort(stop_abort), .wc_pin(wc_pin),
        .data_ack(data_ack), .busy(busy), .next_addr(next_addr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] model [1 << AW];

    // fields: addr(10) count(6) seed(8) wc_mode(2: 0 low, 1 high at load, 2 high after) commit(1)
    localparam logic [26:0] VEC [8] = '{
        {10'h005, 6'd3,  8'd11,  2'd0, 1'b1},
        {10'h01E, 6'd5,  8'd40,  2'd0, 1'b1},
        {10'h040, 6'd34, 8'd90,  2'd0, 1'b1},
        {10'h065, 6'd4,  8'd7,   2'd0, 1'b0},
        {10'h310, 6'd4,  8'd200, 2'd1, 1'b1},
        {10'h320, 6'd3,  8'd60,  2'd0, 1'b1},
        {10'h100, 6'd6,  8'd33,  2'd1, 1'b1},
        {10'h3E0, 6'd2,  8'd5,   2'd2, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        txn_start = 0; addr_load = 0; byte_valid = 0; stop_commit = 0;
        stop_abort = 0; wc_pin = 0; addr_in = '0; byte_data = '0;
    endtask

    task automatic check_row(input logic [AW-1:0] base, input string req);
        for (int j = 0; j < 32; j++) begin
            rd_addr = {base[AW-1:5], 5'(j)};
            #1;
            chk(req, rd_data, model[{base[AW-1:5], 5'(j)}]);
        end
    endtask

    // count busy cycles starting at the current negedge
    task automatic count_busy(output int n);
        n = 0;
        for (int k = 0; k < 400; k++) begin
            if (!busy) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input logic [26:0] v);
        logic [AW-1:0] a;
        int            cnt, mode, bc, exp_bc;
        logic          com, top;
        logic [7:0]    pend [32];
        logic [31:0]   pv;
        logic [4:0]    col;
        a    = v[26:17];
        cnt  = int'(v[16:11]);
        mode = int'(v[2:1]);
        com  = v[0];
        top  = (a[AW-1:AW-2] == 2'b11);
        pv   = '0;
        col  = a[4:0];
        @(negedge clk);
        txn_start = 1;
        @(negedge clk);
        txn_start = 0; addr_load = 1; addr_in = a; wc_pin = (mode == 1);
        @(negedge clk);
        addr_load = 0; wc_pin = (mode == 2);
        for (int k = 0; k < cnt; k++) begin
            byte_valid = 1;
            byte_data  = v[10:3] + 8'(k * 3);
            #1;
            // R5 locked bytes unacknowledged, R6 otherwise acknowledged
            chk((mode == 1 && top) ? "R5 ack" : "R6 ack", data_ack, !(mode == 1 && top));
            if (!(mode == 1 && top)) begin
                pend[col] = byte_data;
                pv[col]   = 1'b1;
            end
            col = col + 1'b1;
            @(negedge clk);
        end
        byte_valid = 0;
        // R8 pointer one past last byte, wrapped in row
        chk("R8 next_addr", next_addr, {a[AW-1:5], col});
        if (com) stop_commit = 1; else stop_abort = 1;
        @(negedge clk);
        stop_commit = 0; stop_abort = 0; wc_pin = 0;
        count_busy(bc);
        exp_bc = (com && pv != 0) ? WCYC : 0;
        // R7 busy length, R10 no busy on empty commit
        chk(exp_bc == 0 ? "R10 busy" : "R7 busy", bc, exp_bc);
        if (com)
            for (int j = 0; j < 32; j++)
                if (pv[j]) model[{a[AW-1:5], 5'(j)}] = pend[j];
        // R2 wrap/overwrite, R3 commit/abort, R4 others untouched, R5/R6/R9 lock
        check_row(a, com ? "R2 R4 R5 R6 R9 row" : "R3 abort row");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int bc;
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        idle_inputs();
        rd_addr = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 ack", data_ack, 0);
        chk("R1 next_addr", next_addr, 0);
        rd_addr = 10'h3FF; #1; chk("R1 rd 3FF", rd_data, 8'hFF);
        rd_addr = 10'h000; #1; chk("R1 rd 000", rd_data, 8'hFF);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R3: a fresh transaction without commit discards the earlier bytes
        @(negedge clk); txn_start = 1;
        @(negedge clk); txn_start = 0; addr_load = 1; addr_in = 10'h0A0;
        @(negedge clk); addr_load = 0; byte_valid = 1; byte_data = 8'h5A;
        @(negedge clk); byte_valid = 0; txn_start = 1;
        @(negedge clk); txn_start = 0; addr_load = 1; addr_in = 10'h0C0;
        @(negedge clk); addr_load = 0; stop_commit = 1;
        @(negedge clk); stop_commit = 0;
        chk("R3 R10 restart busy", busy, 0);
        check_row(10'h0A0, "R3 restart row");

        // R7: strobes during busy are ignored
        @(negedge clk); txn_start = 1;
        @(negedge clk); txn_start = 0; addr_load = 1; addr_in = 10'h200;
        @(negedge clk); addr_load = 0; byte_valid = 1; byte_data = 8'hA1;
        @(negedge clk); byte_data = 8'hB2;
        @(negedge clk); byte_valid = 0; stop_commit = 1;
        @(negedge clk); stop_commit = 0;
        bc = 0;
        for (int k = 0; k < 3; k++) begin bc += busy; @(negedge clk); end
        txn_start = 1; addr_load = 1; addr_in = 10'h000; byte_valid = 1;
        byte_data = 8'h77; stop_commit = 1; stop_abort = 1;
        #1;
        chk("R7 ack during busy", data_ack, 0);
        bc += busy;
        @(negedge clk);
        idle_inputs();
        begin
            int rest;
            count_busy(rest);
            chk("R7 busy with strobes", bc + rest, WCYC);
        end
        chk("R7 pointer kept", next_addr, 10'h202);
        model[10'h200] = 8'hA1;
        model[10'h201] = 8'hB2;
        check_row(10'h200, "R7 committed row");
        check_row(10'h000, "R7 ignored row");
        repeat (3) @(negedge clk);
        chk("R7 idle after", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule